// File: doc/BRIEF.md
# Fixed-Point DC Motor Emulation Core

This core is a real-time hardware model of a DC motor that drives a rotating inertia against a fan-type load. Its torque grows with the square of shaft speed. The core has two phases.

In the setup phase, a pulse on `init_req` captures six motor parameters and clears both states. A bit-serial restoring divider then folds the fixed integration step into two gains: the step divided by the inductance, and the step divided by the inertia. `init_done` rises when both gains are ready.

In the run phase, each accepted `step_req` samples the terminal voltage once. The core then advances current and speed by exactly one forward-Euler step of 1 µs. A single shared, three-stage pipelined multiplier is driven by a fixed 15-cycle schedule, and no division takes place. Completion is reported with a one-cycle `step_done` pulse.

Voltage, current, speed and the parameters are signed Q16.16 values, 16 fractional bits. The step length is a parameter `DT_SCALED`, the step in units of 2^-32 s; the default 4295 stands for 1 µs.

Top module: `dc_motor_core`

## Requirements
- R1: After reset, `i_out`, `w_out`, `init_done` and `step_done` are all 0. All data ports are signed Q16.16. Every parameter must be positive and nonzero.
- R2: The divider works on the parameter raw values. N = `DT_SCALED`·2^16. The current gain is GL = floor(N / L_raw) and the speed gain is GJ = floor(N / J_raw). `init_done` rises at most 80 cycles after the `init_req` pulse and stays high until the next `init_req`.
- R3: The clock edge that samples `init_req` high does four things: it captures the parameters, sets current and speed to 0, lowers `init_done`, and aborts any step in progress.
- R4: One step updates the current using old states only. fm(a,b) means the 64-bit signed product shifted arithmetically right by 16 and truncated to 32 bits. e = V − fm(R,i) − fm(Ke,i→ω), that is e = V − fm(R,i) − fm(Ke,ω), with 32-bit wrap. The new current is i + trunc32((GL·e) >>> 32).
- R5: The same step updates the speed using old states only. The load is fm(fm(k,ω),|ω|), which keeps the sign of ω. The torque is t = fm(Kt,i) − load. The new speed is ω + trunc32((GJ·t) >>> 32).
- R6: `step_req` has no effect while `init_done` is low. No `step_done` pulse follows and the outputs keep their values.
- R7: An accepted step uses `v_in` as sampled on the accepting edge. `step_done` is a single-cycle pulse that arrives within 100 cycles of the request. Both outputs carry the new state when it arrives.
- R8: Between steps, `i_out` and `w_out` hold their values whatever `v_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_req | input | 1 | Start setup: capture parameters, clear states, compute gains |
| step_req | input | 1 | Request one integration step |
| v_in | input | 32 | Terminal voltage, Q16.16 |
| p_inertia | input | 32 | Rotor plus load inertia J |
| p_induct | input | 32 | Winding inductance L |
| p_resist | input | 32 | Winding resistance R |
| p_kemf | input | 32 | Back-EMF constant Ke |
| p_ktorque | input | 32 | Torque constant Kt |
| p_kload | input | 32 | Quadratic load coefficient k |
| init_done | output | 1 | Gains ready; steps accepted |
| step_done | output | 1 | One-cycle pulse at the end of each step |
| i_out | output | 32 | Motor current, Q16.16 |
| w_out | output | 32 | Shaft angular speed, Q16.16 |

## Verification
The bench runs three parameter sets: one with a small inertia and inductance, one with a medium set, and one with realistic motor values. Each set is driven through runs of positive, negative, zero and fractional voltage. After every step, both states are compared against an integer model built from R4 and R5.

The negative runs turn the speed negative, so a wrong sign on the quadratic load shows up. The zero-voltage runs separate back-EMF and resistance errors from input errors. The realistic set exposes gain truncation.

Further checks cover a request before setup, output hold while `v_in` changes, a setup that aborts a step in progress, and a second setup with new parameters, which shows that the gains are recomputed.

// File: rtl/dc_motor_core.sv
module dc_motor_core #(
  parameter int W         = 32,
  parameter int FRAC      = 16,
  parameter int DT_SCALED = 4295
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_req,
  input  logic                step_req,
  input  logic signed [W-1:0] v_in,
  input  logic signed [W-1:0] p_inertia,
  input  logic signed [W-1:0] p_induct,
  input  logic signed [W-1:0] p_resist,
  input  logic signed [W-1:0] p_kemf,
  input  logic signed [W-1:0] p_ktorque,
  input  logic signed [W-1:0] p_kload,
  output logic                init_done,
  output logic                step_done,
  output logic signed [W-1:0] i_out,
  output logic signed [W-1:0] w_out
);
  localparam int PW   = 2*W + 2;
  localparam int SW   = W + FRAC;
  localparam int CNTW = $clog2(W);
  localparam logic [W-1:0] NUM = W'(DT_SCALED) << FRAC;

  typedef enum logic [1:0] {I_IDLE, I_DIVL, I_DIVJ} ist_t;
  ist_t ist;

  logic signed [W-1:0] r_j, r_l, r_res, r_kemf, r_ktq, r_kld;
  logic [W-1:0] g_l, g_j, dq, drem, r_nx, q_nx;
  logic [CNTW-1:0] dcnt;
  logic [W:0] shifted, dvs;
  logic ge;

  logic busy;
  logic [3:0] cyc;
  logic signed [W-1:0] i_st, w_st, v_lat, e_acc, tq, ld1, wabs;
  logic signed [PW-1:0] ma, mb;
  logic signed [SW-1:0] s1, s2, s3;
  logic signed [W-1:0] res_f, res_g;

  assign i_out = i_st;
  assign w_out = w_st;

  assign shifted = {drem, dq[W-1]};
  assign dvs     = {1'b0, (ist == I_DIVL) ? r_l : r_j};
  assign ge      = shifted >= dvs;
  assign r_nx    = ge ? W'(shifted - dvs) : shifted[W-1:0];
  assign q_nx    = {dq[W-2:0], ge};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ist <= I_IDLE; init_done <= 1'b0; dq <= '0; drem <= '0; dcnt <= '0;
      g_l <= '0; g_j <= '0; r_j <= '0; r_l <= '0;
      r_res <= '0; r_kemf <= '0; r_ktq <= '0; r_kld <= '0;
    end else if (init_req) begin
      r_j <= p_inertia; r_l <= p_induct; r_res <= p_resist;
      r_kemf <= p_kemf; r_ktq <= p_ktorque; r_kld <= p_kload;
      init_done <= 1'b0; ist <= I_DIVL; dq <= NUM; drem <= '0; dcnt <= '0;
    end else if (ist != I_IDLE) begin
      dq <= q_nx; drem <= r_nx; dcnt <= dcnt + 1'b1;
      if (dcnt == CNTW'(W-1)) begin
        dq <= NUM; drem <= '0; dcnt <= '0;
        if (ist == I_DIVL) begin
          g_l <= q_nx; ist <= I_DIVJ;
        end else begin
          g_j <= q_nx; ist <= I_IDLE; init_done <= 1'b1;
        end
      end
    end
  end

  assign wabs = w_st[W-1] ? -w_st : w_st;

  always_comb begin
    ma = '0; mb = '0;
    case (cyc)
      4'd0:  begin ma = PW'(r_res);  mb = PW'(i_st);  end
      4'd1:  begin ma = PW'(r_kemf); mb = PW'(w_st);  end
      4'd2:  begin ma = PW'(r_ktq);  mb = PW'(i_st);  end
      4'd3:  begin ma = PW'(r_kld);  mb = PW'(w_st);  end
      4'd6:  begin ma = {{(PW-W){1'b0}}, g_l}; mb = PW'(e_acc); end
      4'd7:  begin ma = PW'(ld1);    mb = PW'(wabs);  end
      4'd11: begin ma = {{(PW-W){1'b0}}, g_j}; mb = PW'(tq); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    s1 <= SW'((ma * mb) >>> FRAC);
    s2 <= s1;
    s3 <= s2;
  end

  assign res_f = s3[W-1:0];
  assign res_g = s3[FRAC +: W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; cyc <= '0; step_done <= 1'b0; i_st <= '0; w_st <= '0;
      v_lat <= '0; e_acc <= '0; tq <= '0; ld1 <= '0;
    end else begin
      step_done <= 1'b0;
      if (init_req) begin
        busy <= 1'b0; cyc <= '0; i_st <= '0; w_st <= '0;
      end else if (!busy) begin
        if (step_req && init_done) begin
          busy <= 1'b1; cyc <= '0; v_lat <= v_in;
        end
      end else begin
        cyc <= cyc + 1'b1;
        case (cyc)
          4'd3:  e_acc <= v_lat - res_f;
          4'd4:  e_acc <= e_acc - res_f;
          4'd5:  tq    <= res_f;
          4'd6:  ld1   <= res_f;
          4'd9:  i_st  <= i_st + res_g;
          4'd10: tq    <= tq - res_f;
          4'd14: begin w_st <= w_st + res_g; busy <= 1'b0; step_done <= 1'b1; end
          default: ;
        endcase
      end
    end
  end

  a_r3_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> (i_out == '0 && w_out == '0 && !init_done));
  a_r6_no_step_without_init: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> init_done);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> !step_done);
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !init_req) |=> ($stable(i_out) && $stable(w_out)));
  a_r2_gains_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(g_l) && $stable(g_j)));
endmodule

// File: tb/sim_dc_motor_core.sv
module sim_dc_motor_core;
  logic clk = 1'b0, rst_n = 1'b0, init_req = 1'b0, step_req = 1'b0;
  logic signed [31:0] v_in = '0, p_j = '0, p_l = '0, p_r = '0, p_ke = '0, p_kt = '0, p_k = '0;
  logic init_done, step_done;
  logic signed [31:0] i_out, w_out;
  int n_cmp = 0, n_bad = 0, cycles = 0;
  longint mgl, mgj;
  logic signed [31:0] mi, mw;

  always #10 clk = ~clk;

  dc_motor_core u0 (.clk(clk), .rst_n(rst_n), .init_req(init_req), .step_req(step_req),
    .v_in(v_in), .p_inertia(p_j), .p_induct(p_l), .p_resist(p_r), .p_kemf(p_ke),
    .p_ktorque(p_kt), .p_kload(p_k), .init_done(init_done), .step_done(step_done),
    .i_out(i_out), .w_out(w_out));

  task automatic check(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic signed [31:0] fm(input logic signed [31:0] a, input logic signed [31:0] b);
    longint p = longint'(a) * longint'(b);
    return 32'(p >>> 16);
  endfunction

  function automatic logic signed [31:0] gm(input longint g, input logic signed [31:0] e);
    return 32'((g * longint'(e)) >>> 32);
  endfunction

  task automatic model_step(input logic signed [31:0] v);
    logic signed [31:0] e, t, ld, wa, ni, nw;
    e  = v - fm(p_r, mi) - fm(p_ke, mw);
    wa = mw[31] ? -mw : mw;
    ld = fm(fm(p_k, mw), wa);
    t  = fm(p_kt, mi) - ld;
    ni = mi + gm(mgl, e);
    nw = mw + gm(mgj, t);
    mi = ni; mw = nw;
  endtask

  task automatic do_init(input int j, input int l, input int r, input int ke, input int kt, input int k);
    int n = 0;
    @(negedge clk);
    p_j = j; p_l = l; p_r = r; p_ke = ke; p_kt = kt; p_k = k; init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
    check("R3 init clears current", i_out, 0);
    check("R3 init clears speed", w_out, 0);
    check("R3 init lowers init_done", init_done, 0);
    while (!init_done && n < 200) begin @(negedge clk); n++; end
    check("R2 init_done within 80 cycles", (n <= 80), 1);
    mgl = (longint'(4295) << 16) / l;
    mgj = (longint'(4295) << 16) / j;
    mi = 0; mw = 0;
  endtask

  task automatic do_step(input logic signed [31:0] v);
    int n = 0;
    @(negedge clk);
    v_in = v; step_req = 1'b1;
    @(negedge clk);
    step_req = 1'b0; v_in = ~v;
    while (!step_done && n < 200) begin @(negedge clk); n++; end
    check("R7 step_done within 100 cycles", (n < 100), 1);
    model_step(v);
    check("R4 current update", i_out, mi);
    check("R5 speed update", w_out, mw);
    @(negedge clk);
    check("R7 step_done single cycle", step_done, 0);
  endtask

  task automatic run_set(input int j, input int l, input int r, input int ke, input int kt, input int k);
    logic signed [31:0] vs [4];
    vs[0] = 32'sd786432; vs[1] = -32'sd786432; vs[2] = 32'sd0; vs[3] = 32'sd229376;
    do_init(j, l, r, ke, kt, k);
    foreach (vs[s]) for (int q = 0; q < 12; q++) do_step(vs[s]);
  endtask

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    check("R1 reset current", i_out, 0);
    check("R1 reset speed", w_out, 0);
    check("R1 reset init_done", init_done, 0);
    check("R1 reset step_done", step_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    step_req = 1'b1; v_in = 32'sd786432;
    @(negedge clk);
    step_req = 1'b0;
    seen = 0;
    for (int c = 0; c < 30; c++) begin @(negedge clk); if (step_done) seen++; end
    check("R6 no step before init", seen, 0);
    check("R6 current untouched", i_out, 0);
    check("R6 speed untouched", w_out, 0);

    run_set(1, 4, 16384, 13107, 262144, 131072);
    run_set(3, 9, 65536, 65536, 131072, 32768);
    run_set(655, 66, 65536, 3277, 3277, 66);

    do_init(1, 4, 16384, 13107, 262144, 131072);
    for (int q = 0; q < 6; q++) do_step(32'sd786432);
    v_in = -32'sd400000;
    repeat (20) @(negedge clk);
    check("R8 current held", i_out, mi);
    check("R8 speed held", w_out, mw);

    @(negedge clk);
    step_req = 1'b1; v_in = 32'sd786432;
    @(negedge clk);
    step_req = 1'b0;
    repeat (4) @(negedge clk);
    seen = 0;
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
    for (int c = 0; c < 90; c++) begin @(negedge clk); if (step_done) seen++; end
    check("R3 aborted step gives no done", seen, 0);
    check("R3 abort leaves current zero", i_out, 0);
    check("R3 abort leaves speed zero", w_out, 0);
    check("R2 init_done after re-init", init_done, 1);
    mi = 0; mw = 0;
    for (int q = 0; q < 5; q++) do_step(-32'sd500000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule